// File: doc/BRIEF.md
# Timer Interrupt Arbiter with DMA Steering

This block gathers the interrupt sources of a five-channel timer. Each channel has three sources: a compare/capture A event, a compare/capture B event and a counter overflow, which makes fifteen sources. The block keeps one status flag per source. The timer's event pulses set these flags. The CPU clears a flag with a write-zero strobe, and the DMA engine clears one with an acknowledge.

A source is pending when its flag and its enable are both 1. The block picks the highest-ranked pending source and presents a single registered CPU request together with that source's vector index. A per-channel group bit lets software move any set of channels above the others while the block is running.

Channels 0 to 3 can each steer their A source to a DMA trigger line instead of the CPU. A steered source takes no part in CPU arbitration.

Top module: `tmr_irq_arbiter`

## Requirements
- R1: A pulse on `evt_set_i[i]` sets flag i, which is seen on `flag_o[i]` after the next rising clock edge. The flag stays set until it is cleared. The source index is i = channel*3 + kind, where kind is 0 for A, 1 for B and 2 for overflow.
- R2: A pulse on `flag_clr_i[i]` clears flag i at the next edge. If `evt_set_i[i]` is high in the same cycle, the flag stays set, because a set takes precedence over any clear.
- R3: Source i is pending only when `flag_o[i]` and `irq_en_i[i]` are both 1. `irq_req_o` is registered: after each edge it is 1 exactly when at least one source that is not steered to DMA was pending in the cycle before that edge.
- R4: When all group bits are equal, the lowest pending source index wins. This ranks channel 0 above channel 4 and, within a channel, A above B above overflow. `irq_vec_o` carries the winning index in the range 0 to 14.
- R5: Every channel whose bit is set in `grp_hi_i` ranks above every channel whose bit is clear. Within each group the order of R4 applies.
- R6: For channels c = 0 to 3, `dma_req_o[c]` is the combinational AND of flag c*3, `irq_en_i[c*3]` and `dma_sel_i[c]`. A source steered in this way never wins CPU arbitration.
- R7: `dma_sel_i` has no effect on B sources, on overflow sources or on the A source of channel 4. These sources always take part in CPU arbitration.
- R8: A pulse on `dma_ack_i[c]` clears flag c*3 at the next edge, unless `evt_set_i[c*3]` is high in the same cycle.
- R9: When no source is pending for the CPU, `irq_req_o` falls after the next edge and `irq_vec_o` keeps its previous value.
- R10: While `rst` is high (synchronous, active high), all flags, `irq_req_o` and `irq_vec_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 15 | Hardware set pulses, one per source |
| flag_clr_i | input | 15 | CPU write-zero clear strobes, one per source |
| irq_en_i | input | 15 | Interrupt enables, one per source |
| dma_sel_i | input | 4 | Steer the A source of channels 0 to 3 to DMA |
| grp_hi_i | input | 5 | Per-channel high-priority group bit |
| dma_ack_i | input | 4 | DMA acknowledge, clears the A flag of that channel |
| flag_o | output | 15 | Status flags |
| dma_req_o | output | 4 | DMA trigger per channel 0 to 3 |
| irq_req_o | output | 1 | Registered CPU interrupt request |
| irq_vec_o | output | 4 | Vector index of the winning source |

## Verification
The bench drives a set and a clear into the same flag in the same cycle. A design that lets the clear win would drop a fresh event, and the flag or the request would vanish. It raises the group bit of channel 4 while channel 0 is pending, so a fixed-priority design would keep reporting vector 0. It steers channel 0's A source to DMA while B and overflow sources and channel 4's A source stay pending. A design with wrong steering would lose vector 0 to the CPU, assert a trigger for a source that cannot be steered, or mask the wrong source. It also empties the pending set and checks that the vector does not fall back to zero.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    parameter int NUM_CH     = 5;
    parameter int SRC_PER_CH = 3;
    parameter int DMA_CH     = 4;
    localparam int NUM_SRC   = NUM_CH * SRC_PER_CH;
    localparam int VEC_W     = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        KIND_A   = 2'd0,
        KIND_B   = 2'd1,
        KIND_OVF = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } win_t;

    function automatic int src_index(input int ch, input src_kind_e kind);
        return ch * SRC_PER_CH + int'(kind);
    endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tmr_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [DMA_CH-1:0]  ack_i,
    output logic [NUM_SRC-1:0] flag_o
);
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] flag_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_ack
        if ((s % SRC_PER_CH) == int'(KIND_A) && (s / SRC_PER_CH) < DMA_CH) begin : g_dma
            assign ack_mask[s] = ack_i[s / SRC_PER_CH];
        end else begin : g_none
            assign ack_mask[s] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= set_i | (flag_q & ~(clr_i | ack_mask));
    end

    assign flag_o = flag_q;

    p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (|(ack_mask & ~set_i)) |=> ((flag_q & $past(ack_mask & ~set_i)) == '0));
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
    import tmr_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [DMA_CH-1:0]  dma_sel_i,
    output logic [NUM_SRC-1:0] cpu_pend_o,
    output logic [DMA_CH-1:0]  dma_req_o
);
    logic [NUM_SRC-1:0] pend;
    assign pend = flag_i & en_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BA = c * SRC_PER_CH + int'(KIND_A);
        if (c < DMA_CH) begin : g_steer
            assign dma_req_o[c]   = pend[BA] & dma_sel_i[c];
            assign cpu_pend_o[BA] = pend[BA] & ~dma_sel_i[c];
        end else begin : g_plain
            assign cpu_pend_o[BA] = pend[BA];
        end
        for (genvar k = 1; k < SRC_PER_CH; k++) begin : g_rest
            assign cpu_pend_o[c * SRC_PER_CH + k] = pend[c * SRC_PER_CH + k];
        end
    end
endmodule

// File: rtl/tmr_irq_pick.sv
module tmr_irq_pick
    import tmr_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_CH-1:0]  grp_hi_i,
    output win_t               win_o
);
    always_comb begin
        win_o = '0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                for (int k = 0; k < SRC_PER_CH; k++) begin
                    if (!win_o.valid && (grp_hi_i[ch] == (pass == 0))
                        && pend_i[ch * SRC_PER_CH + k]) begin
                        win_o.valid = 1'b1;
                        win_o.vec   = VEC_W'(ch * SRC_PER_CH + k);
                    end
                end
            end
        end
    end

    always_comb begin
        if (win_o.valid) begin
            p_win_pending_r4: assert (pend_i[win_o.vec]);
        end
    end
endmodule

// File: rtl/tmr_irq_arbiter.sv
module tmr_irq_arbiter
    import tmr_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_set_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    input  logic [NUM_SRC-1:0] irq_en_i,
    input  logic [DMA_CH-1:0]  dma_sel_i,
    input  logic [NUM_CH-1:0]  grp_hi_i,
    input  logic [DMA_CH-1:0]  dma_ack_i,
    output logic [NUM_SRC-1:0] flag_o,
    output logic [DMA_CH-1:0]  dma_req_o,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] cpu_pend;
    win_t               pick;

    tmr_irq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_set_i),
        .clr_i  (flag_clr_i),
        .ack_i  (dma_ack_i),
        .flag_o (flags)
    );

    tmr_irq_route u_route (
        .flag_i     (flags),
        .en_i       (irq_en_i),
        .dma_sel_i  (dma_sel_i),
        .cpu_pend_o (cpu_pend),
        .dma_req_o  (dma_req_o)
    );

    tmr_irq_pick u_pick (
        .pend_i   (cpu_pend),
        .grp_hi_i (grp_hi_i),
        .win_o    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req_o <= 1'b0;
            irq_vec_o <= '0;
        end else begin
            irq_req_o <= pick.valid;
            if (pick.valid) irq_vec_o <= pick.vec;
        end
    end

    assign flag_o = flags;

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !pick.valid |=> $stable(irq_vec_o));

    p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (int'(irq_vec_o) < NUM_SRC));

    p_req_needs_pend_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_pend == '0) |=> !irq_req_o);
endmodule

// File: tb/tb_tmr_irq_arbiter.sv
module tb_tmr_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] evt_set_i = '0, flag_clr_i = '0, irq_en_i = '0;
    logic [3:0]  dma_sel_i = '0, dma_ack_i = '0;
    logic [4:0]  grp_hi_i = '0;
    logic [14:0] flag_o;
    logic [3:0]  dma_req_o;
    logic        irq_req_o;
    logic [3:0]  irq_vec_o;

    int checks = 0, failures = 0, cycles = 0;
    string tag = "R10";

    // reference model state
    logic [14:0] m_flag = '0;
    logic        m_req  = 1'b0;
    logic [3:0]  m_vec  = '0;

    always #4 clk = ~clk;

    tmr_irq_arbiter dut (
        .clk(clk), .rst(rst), .evt_set_i(evt_set_i), .flag_clr_i(flag_clr_i),
        .irq_en_i(irq_en_i), .dma_sel_i(dma_sel_i), .grp_hi_i(grp_hi_i),
        .dma_ack_i(dma_ack_i), .flag_o(flag_o), .dma_req_o(dma_req_o),
        .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
    );

    function automatic logic [3:0] exp_dma(input logic [14:0] f);
        logic [3:0] d;
        for (int c = 0; c < 4; c++) d[c] = f[c*3] & irq_en_i[c*3] & dma_sel_i[c];
        return d;
    endfunction

    // model: score-based pick over the pre-edge state, then flag update
    always @(posedge clk) begin
        int best, best_score;
        best = -1; best_score = 1000;
        for (int i = 0; i < 15; i++) begin
            bit steered, p;
            int sc;
            steered = (i % 3 == 0) && (i / 3 < 4) && dma_sel_i[i/3];
            p = m_flag[i] && irq_en_i[i] && !steered;
            sc = (grp_hi_i[i/3] ? 0 : 100) + i;
            if (p && sc < best_score) begin best_score = sc; best = i; end
        end
        if (rst) begin
            m_req = 0; m_vec = 0; m_flag = '0;
        end else begin
            m_req = (best >= 0);
            if (best >= 0) m_vec = 4'(best);
            for (int i = 0; i < 15; i++) begin
                bit ak;
                ak = (i % 3 == 0) && (i / 3 < 4) && dma_ack_i[i/3];
                m_flag[i] = evt_set_i[i] | (m_flag[i] & ~flag_clr_i[i] & ~ak);
            end
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        chk({tag, " flags"}, int'(flag_o), int'(m_flag));
        chk({tag, " dma"}, int'(dma_req_o), int'(exp_dma(m_flag)));
        chk({tag, " req"}, int'(irq_req_o), int'(m_req));
        chk({tag, " vec"}, int'(irq_vec_o), int'(m_vec));
    end

    task automatic drive(input logic [14:0] s, input logic [14:0] c, input logic [3:0] a);
        @(negedge clk);
        evt_set_i = s; flag_clr_i = c; dma_ack_i = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, '0, '0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        // R10: reset state
        chk("R10 flags", int'(flag_o), 0);
        chk("R10 req", int'(irq_req_o), 0);
        chk("R10 vec", int'(irq_vec_o), 0);
        @(negedge clk); rst = 0; irq_en_i = '1;

        tag = "R1";
        drive(15'h0080, '0, '0); idle(2);
        chk("R1 vec", int'(irq_vec_o), 7);

        tag = "R4";
        drive(15'h4001, '0, '0); idle(2);
        chk("R4 vec", int'(irq_vec_o), 0);

        tag = "R5";
        @(negedge clk); grp_hi_i = 5'b10000; idle(2);
        chk("R5 vec", int'(irq_vec_o), 14);
        @(negedge clk); grp_hi_i = 5'b00110; idle(2);
        chk("R5 vec grp", int'(irq_vec_o), 7);
        @(negedge clk); grp_hi_i = '0;

        tag = "R2";
        drive(15'h0008, '1, '0); idle(2);
        chk("R2 flags", int'(flag_o), 15'h0008);
        chk("R2 vec", int'(irq_vec_o), 3);

        tag = "R6";
        drive('0, '1, '0);
        @(negedge clk); dma_sel_i = 4'b0001;
        drive(15'h0201, '0, '0); idle(2);
        chk("R6 dma", int'(dma_req_o), 1);
        chk("R6 vec", int'(irq_vec_o), 9);

        tag = "R7";
        drive('0, '1, '0);
        @(negedge clk); dma_sel_i = 4'b1111;
        drive(15'h1030, '0, '0); idle(2);
        chk("R7 dma", int'(dma_req_o), 0);
        chk("R7 vec", int'(irq_vec_o), 4);

        tag = "R8";
        drive(15'h0001, '1, '0); idle(1);
        chk("R8 dma before ack", int'(dma_req_o), 1);
        drive('0, '0, 4'b0001); idle(1);
        chk("R8 ack clears", int'(flag_o[0]), 0);
        drive(15'h0001, '0, '0); drive(15'h0001, '0, 4'b0001); idle(1);
        chk("R8 set wins", int'(flag_o[0]), 1);

        tag = "R9";
        @(negedge clk); dma_sel_i = '0;
        drive(15'h0400, '1, '0); idle(2);
        drive('0, '1, '0); idle(2);
        chk("R9 req", int'(irq_req_o), 0);
        chk("R9 vec held", int'(irq_vec_o), 10);

        tag = "R3";
        @(negedge clk); irq_en_i = '0;
        drive(15'h0100, '0, '0); idle(2);
        chk("R3 masked", int'(irq_req_o), 0);
        @(negedge clk); irq_en_i = 15'h0100; idle(1);
        chk("R3 enabled", int'(irq_req_o), 1);
        chk("R3 vec", int'(irq_vec_o), 8);

        // mixed stimulus, compared against the model every cycle (R3, R5, R6)
        tag = "R3";
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            evt_set_i  = 15'($urandom) & 15'($urandom) & 15'($urandom);
            flag_clr_i = 15'($urandom) & 15'($urandom);
            dma_ack_i  = 4'($urandom) & 4'($urandom);
            if (n % 17 == 0) begin
                irq_en_i = 15'($urandom); dma_sel_i = 4'($urandom); grp_hi_i = 5'($urandom);
            end
        end
        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule